// File: doc/BRIEF.md
# Mains-Locked Bit Clock with Zero-Cross Phase Offset

This block derives the bit-rate strobe and the frame-start pulse of a power-line modem from the mains. A phase counter runs from the system clock and steps through one mains half period. Each rising zero crossing re-phases that counter. The counter is not cleared at a crossing. It is loaded with the adjust value multiplied by a fixed step length, which by default is 624 system cycles, or 26 µs at 24 MHz. Because of this load, the frame start falls earlier than the crossing-aligned point by exactly the programmed offset. That cancels the delay of an external detector such as an opto-coupler or a threshold comparator.

The crossing input is synchronised with two flops, and only its rising edge acts. Between crossings the counter runs freely and wraps once per half period. This keeps the strobes going when a crossing is missing. The half period is divided into a fixed number of bit slots, for example three slots of a 300-baud bit at 50 Hz. A strobe is issued at the start of each slot.

A lock flag reports that the crossings arrive regularly. It is set after four consecutive crossing intervals fall inside a ±1 % window around the nominal half period. It drops when an interval falls outside that window or when a crossing does not arrive at all.

Top module: `mzc_bitclk`

## Requirements
- R1: While reset is active and in the cycle after it is released, `bit_stb`, `frame_stb` and `mains_lock` are all 0.
- R2: `zc_in` acts only through its rising edge, two clock edges after it rises. If `zc_in` is held high, the counter is not loaded again.
- R3: With `zc_adj` = 0, a rising edge of `zc_in` before clock edge Z makes `frame_stb` 1 after clock edge Z+2 and 0 after edge Z+1.
- R4: With `zc_adj` = k > 0, a crossing before edge Z makes `frame_stb` 1 after edge Z+2+HALF_CYC−k·STEP_CYC and not after edge Z+2. The frame start therefore comes k·STEP_CYC cycles before the crossing-aligned point.
- R5: With no crossings, `frame_stb` is a one-cycle pulse every HALF_CYC cycles. The first pulse comes HALF_CYC edges after reset is released.
- R6: `bit_stb` pulses when the phase reaches each multiple of HALF_CYC/BIT_SLOTS. This gives BIT_SLOTS pulses per half period, and one of them coincides with every `frame_stb`.
- R7: A change of `zc_adj` between crossings does not move the current frame timing. The new value applies from the next crossing.
- R8: `mains_lock` rises one edge after the fourth consecutive crossing whose interval lies in [HALF_CYC−HALF_CYC/TOL_DIV, HALF_CYC+HALF_CYC/TOL_DIV]. The first crossing after reset does not count as an interval.
- R9: A crossing whose interval lies outside that window clears `mains_lock` at the next edge. A crossing inside the window keeps the lock.
- R10: If no crossing arrives for HALF_CYC+HALF_CYC/TOL_DIV+1 edges after the last crossing took effect, `mains_lock` clears.
- R11: `zc_adj` = 255 applies the full 255·STEP_CYC offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| zc_in | input | 1 | Zero-cross detector output, asynchronous |
| zc_adj | input | 8 | Phase offset in steps of STEP_CYC cycles |
| bit_stb | output | 1 | One-cycle pulse at the start of each bit slot |
| frame_stb | output | 1 | One-cycle frame-start pulse |
| mains_lock | output | 1 | Crossings are regular within the window |

## Verification
Each result is due at a fixed edge counted from the edge before which `zc_in` rose. The load takes effect two edges later, because of the two synchroniser stages and the counter register. Frame and slot strobes then follow at that edge plus the phase distance. The lock flag changes one edge after the deciding crossing takes effect, or one edge after the interval counter passes the window. The bench keeps a cycle count of its own and samples on falling edges at exactly the computed cycle. Where a wrong design would plausibly pulse one cycle early, it also checks the cycle before.

// File: rtl/mzc_pkg.sv
// Package: shared types and derived-constant helpers for the mains-locked
// bit clock. Assumes integer parameters small enough for 32-bit math.
package mzc_pkg;

    typedef logic [7:0] adj_t;

    // Half-width of the lock window in cycles for a given divisor.
    function automatic int unsigned tol_cycles(input int unsigned half, input int unsigned div);
        return half / div;
    endfunction

endpackage

// File: rtl/mzc_zc_sync.sv
// Two-flop synchroniser plus rising-edge detector for the zero-cross input.
// Assumes zc_in is asynchronous and its pulses last at least two clocks.
module mzc_zc_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic zc_in,
    output logic zc_rise
);

    logic s1_q, s2_q, s3_q;

    // Purpose: resynchronise the input and keep one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= zc_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // Purpose: flag the first synchronised high cycle.
    always_comb zc_rise = s2_q & ~s3_q;

endmodule

// File: rtl/mzc_phase_ctr.sv
// Phase counter over one mains half period. A crossing loads adj*STEP_CYC;
// otherwise the counter advances and wraps. Frame and slot strobes are issued
// when the phase moves onto zero or onto a slot boundary.
// Assumes 255*STEP_CYC < HALF_CYC and HALF_CYC divisible by BIT_SLOTS.
module mzc_phase_ctr
    import mzc_pkg::*;
#(
    parameter int unsigned HALF_CYC  = 240000,
    parameter int unsigned STEP_CYC  = 624,
    parameter int unsigned BIT_SLOTS = 3,
    localparam int unsigned PH_W     = $clog2(HALF_CYC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            zc_rise,
    input  adj_t            adj,
    output logic [PH_W-1:0] phase_q,
    output logic            frame_stb,
    output logic            bit_stb
);

    localparam int unsigned SLOT_CYC = HALF_CYC / BIT_SLOTS;
    localparam logic [PH_W-1:0] LAST = PH_W'(HALF_CYC - 1);

    logic [PH_W-1:0]      load_val;
    logic [PH_W-1:0]      phase_d;
    logic [BIT_SLOTS-1:0] slot_hit;
    logic                 moved;

    // Purpose: scale the adjust value into a phase preload.
    always_comb load_val = PH_W'(adj) * PH_W'(STEP_CYC);

    // Purpose: next phase: preload on a crossing, else advance with wrap.
    always_comb begin
        if (zc_rise)
            phase_d = load_val;
        else if (phase_q == LAST)
            phase_d = '0;
        else
            phase_d = phase_q + PH_W'(1);
    end

    // Purpose: a strobe needs the phase to arrive at a point, not sit on it.
    always_comb moved = (phase_d != phase_q);

    // One comparator per bit-slot boundary.
    for (genvar j = 0; j < BIT_SLOTS; j++) begin : g_slot
        always_comb slot_hit[j] = (phase_d == PH_W'(j * SLOT_CYC));
    end

    // Purpose: register phase and strobes together so they stay aligned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= '0;
            frame_stb <= 1'b0;
            bit_stb   <= 1'b0;
        end else begin
            phase_q   <= phase_d;
            frame_stb <= moved && (phase_d == '0);
            bit_stb   <= moved && (|slot_hit);
        end
    end

endmodule

// File: rtl/mzc_lock_det.sv
// Lock detector: measures the cycles between crossings and counts consecutive
// intervals inside +/- HALF_CYC/TOL_DIV of the nominal half period.
// Assumes zc_rise is a single-cycle pulse.
module mzc_lock_det
    import mzc_pkg::*;
#(
    parameter int unsigned HALF_CYC = 240000,
    parameter int unsigned TOL_DIV  = 100,
    parameter int unsigned LOCK_RUN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic zc_rise,
    output logic lock
);

    localparam int unsigned TOL  = tol_cycles(HALF_CYC, TOL_DIV);
    localparam int unsigned LO   = HALF_CYC - TOL;
    localparam int unsigned HI   = HALF_CYC + TOL;
    localparam int unsigned IV_W = $clog2(HI + 2);
    localparam int unsigned GC_W = $clog2(LOCK_RUN + 1);

    logic [IV_W-1:0] ivl_q;
    logic [GC_W-1:0] good_q;
    logic            in_win;
    logic            overdue;

    // Purpose: cycles since the last crossing, saturating just past the window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ivl_q <= IV_W'(HI + 1);
        else if (zc_rise)
            ivl_q <= IV_W'(1);
        else if (!overdue)
            ivl_q <= ivl_q + IV_W'(1);
    end

    // Purpose: classify the current interval against the window.
    always_comb begin
        overdue = (ivl_q > IV_W'(HI));
        in_win  = (ivl_q >= IV_W'(LO)) && !overdue;
    end

    // Purpose: run length of good intervals; any bad or missing one restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            good_q <= '0;
        else if (zc_rise) begin
            if (!in_win)
                good_q <= '0;
            else if (good_q != GC_W'(LOCK_RUN))
                good_q <= good_q + GC_W'(1);
        end else if (overdue)
            good_q <= '0;
    end

    // Purpose: lock when the run reaches its target.
    always_comb lock = (good_q == GC_W'(LOCK_RUN));

endmodule

// File: rtl/mzc_bitclk.sv
// Top: mains-locked bit clock with programmable zero-cross phase offset.
// Assumes a free-running system clock; all outputs are registered or
// derived from registers, and change only on rising clock edges.
module mzc_bitclk
    import mzc_pkg::*;
#(
    parameter int unsigned HALF_CYC  = 240000,
    parameter int unsigned STEP_CYC  = 624,
    parameter int unsigned BIT_SLOTS = 3,
    parameter int unsigned TOL_DIV   = 100,
    parameter int unsigned LOCK_RUN  = 4,
    localparam int unsigned PH_W     = $clog2(HALF_CYC + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       zc_in,
    input  logic [7:0] zc_adj,
    output logic       bit_stb,
    output logic       frame_stb,
    output logic       mains_lock
);

    logic            zc_rise;
    logic [PH_W-1:0] phase_q;

    mzc_zc_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .zc_in   (zc_in),
        .zc_rise (zc_rise)
    );

    mzc_phase_ctr #(
        .HALF_CYC  (HALF_CYC),
        .STEP_CYC  (STEP_CYC),
        .BIT_SLOTS (BIT_SLOTS)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .zc_rise   (zc_rise),
        .adj       (adj_t'(zc_adj)),
        .phase_q   (phase_q),
        .frame_stb (frame_stb),
        .bit_stb   (bit_stb)
    );

    mzc_lock_det #(
        .HALF_CYC (HALF_CYC),
        .TOL_DIV  (TOL_DIV),
        .LOCK_RUN (LOCK_RUN)
    ) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .zc_rise (zc_rise),
        .lock    (mains_lock)
    );

endmodule

// File: rtl/mzc_bitclk_chk.sv
// Checker for mzc_bitclk: relates the input edge, the phase register and the
// output strobes over time. Attached to every instance by the bind below.
module mzc_bitclk_chk #(
    parameter int unsigned HALF_CYC = 240000,
    parameter int unsigned STEP_CYC = 624,
    localparam int unsigned PH_W    = $clog2(HALF_CYC + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            zc_in,
    input logic [7:0]      zc_adj,
    input logic            zc_rise,
    input logic [PH_W-1:0] phase_q,
    input logic            bit_stb,
    input logic            frame_stb,
    input logic            mains_lock
);

    // R2: an acted-on edge comes from an input that rose two edges earlier.
    p_sync_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        zc_rise |-> ($past(zc_in, 2) && !$past(zc_in, 3)));

    // R4: the crossing loads the scaled offset into the phase.
    p_load_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        zc_rise |=> (phase_q == PH_W'($past(zc_adj)) * PH_W'(STEP_CYC)));

    // R5: phase never leaves the half period.
    p_phase_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q < PH_W'(HALF_CYC));

    // R5: frame start is one cycle wide.
    p_frame_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> !frame_stb);

    // R6: every frame start is also a slot start.
    p_frame_on_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> bit_stb);

    // R8: lock only rises on an acted-on crossing.
    p_lock_on_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mains_lock) |-> $past(zc_rise));

endmodule

bind mzc_bitclk mzc_bitclk_chk #(
    .HALF_CYC (HALF_CYC),
    .STEP_CYC (STEP_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .zc_in      (zc_in),
    .zc_adj     (zc_adj),
    .zc_rise    (zc_rise),
    .phase_q    (phase_q),
    .bit_stb    (bit_stb),
    .frame_stb  (frame_stb),
    .mains_lock (mains_lock)
);

// File: tb/mzc_bitclk_tb_top.sv
// Directed bench for mzc_bitclk with a shortened half period.
module mzc_bitclk_tb_top;

    localparam int P     = 1200;
    localparam int STEP  = 4;
    localparam int SLOTS = 4;
    localparam int TDIV  = 100;
    localparam int TOL   = P / TDIV;
    localparam int HI    = P + TOL;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       zc_in = 1'b0;
    logic [7:0] zc_adj = 8'd0;
    logic       bit_stb, frame_stb, mains_lock;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    int rel = 0;
    bit done = 1'b0;

    mzc_bitclk #(
        .HALF_CYC (P),
        .STEP_CYC (STEP),
        .BIT_SLOTS(SLOTS),
        .TOL_DIV  (TDIV),
        .LOCK_RUN (4)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .zc_in      (zc_in),
        .zc_adj     (zc_adj),
        .bit_stb    (bit_stb),
        .frame_stb  (frame_stb),
        .mains_lock (mains_lock)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
        end
    endtask

    task automatic at_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        zc_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rel = cyc;
    endtask

    // Raise the crossing so that it is captured at edge z; hold for len cycles.
    task automatic zc_pulse(input int z, input int len);
        at_cyc(z - 1);
        zc_in = 1'b1;
        fork
            begin
                at_cyc(z - 1 + len);
                zc_in = 1'b0;
            end
        join_none
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 bit_stb in reset", bit_stb, 1'b0);
        chk("R1 frame_stb in reset", frame_stb, 1'b0);
        chk("R1 lock in reset", mains_lock, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 frame_stb after release", frame_stb, 1'b0);
    endtask

    task automatic t_free_run();
        do_reset();
        at_cyc(rel + P - 1);
        chk("R5 no early frame", frame_stb, 1'b0);
        at_cyc(rel + P);
        chk("R5 first free frame", frame_stb, 1'b1);
        at_cyc(rel + P + 1);
        chk("R5 frame single cycle", frame_stb, 1'b0);
        at_cyc(rel + 2 * P);
        chk("R5 second free frame", frame_stb, 1'b1);
    endtask

    task automatic t_zero_adj();
        int z;
        do_reset();
        zc_adj = 8'd0;
        z = rel + 20;
        zc_pulse(z, 5);
        at_cyc(z + 1);
        chk("R3 frame not yet", frame_stb, 1'b0);
        at_cyc(z + 2);
        chk("R3 frame at crossing+2", frame_stb, 1'b1);
    endtask

    task automatic t_offset(input logic [7:0] k, input string tag);
        int z, d;
        do_reset();
        zc_adj = k;
        z = rel + 20;
        d = P - int'(k) * STEP;
        zc_pulse(z, 5);
        at_cyc(z + 2);
        chk({tag, " no frame at load"}, frame_stb, 1'b0);
        at_cyc(z + 1 + d);
        chk({tag, " frame not early"}, frame_stb, 1'b0);
        at_cyc(z + 2 + d);
        chk({tag, " frame advanced by offset"}, frame_stb, 1'b1);
    endtask

    task automatic t_level_hold();
        int z;
        do_reset();
        zc_adj = 8'd50;
        z = rel + 20;
        zc_pulse(z, 1500);
        at_cyc(z + 1002);
        chk("R2 held level loads once", frame_stb, 1'b1);
        at_cyc(z + 1003);
        chk("R2 frame single after hold", frame_stb, 1'b0);
        at_cyc(z + 1510);
    endtask

    task automatic t_slots();
        int z;
        do_reset();
        zc_adj = 8'd0;
        z = rel + 20;
        zc_pulse(z, 5);
        for (int j = 0; j < SLOTS; j++) begin
            at_cyc(z + 1 + j * (P / SLOTS));
            chk("R6 no slot early", bit_stb, 1'b0);
            at_cyc(z + 2 + j * (P / SLOTS));
            chk("R6 slot strobe", bit_stb, 1'b1);
        end
        do_reset();
        zc_adj = 8'd10;
        z = rel + 20;
        zc_pulse(z, 5);
        at_cyc(z + 2);
        chk("R6 no slot at offset load", bit_stb, 1'b0);
        at_cyc(z + 2 + (P / SLOTS) - 40);
        chk("R6 slot after offset", bit_stb, 1'b1);
    endtask

    task automatic t_adj_change();
        int z, z2;
        do_reset();
        zc_adj = 8'd100;
        z = rel + 20;
        zc_pulse(z, 5);
        at_cyc(z + 10);
        zc_adj = 8'd200;
        at_cyc(z + 802);
        chk("R7 old offset holds", frame_stb, 1'b1);
        z2 = z + P;
        zc_pulse(z2, 5);
        at_cyc(z2 + 401);
        chk("R7 new offset not early", frame_stb, 1'b0);
        at_cyc(z2 + 402);
        chk("R7 new offset at next crossing", frame_stb, 1'b1);
    endtask

    // Five crossings P apart starting at z0; returns the last one.
    task automatic acquire(input int z0, output int zl);
        for (int i = 0; i < 5; i++) begin
            zc_pulse(z0 + i * P, 5);
            if (i == 3) begin
                at_cyc(z0 + 3 * P + 2);
                chk("R8 no lock after three intervals", mains_lock, 1'b0);
            end
        end
        zl = z0 + 4 * P;
        at_cyc(zl + 1);
        chk("R8 lock not early", mains_lock, 1'b0);
        at_cyc(zl + 2);
        chk("R8 lock after four intervals", mains_lock, 1'b1);
    endtask

    task automatic t_lock_timeout();
        int zl;
        do_reset();
        zc_adj = 8'd0;
        acquire(rel + 10, zl);
        at_cyc(zl + 2 + HI);
        chk("R10 lock held to window end", mains_lock, 1'b1);
        at_cyc(zl + 3 + HI);
        chk("R10 lock lost on missing crossing", mains_lock, 1'b0);
    endtask

    task automatic t_lock_window();
        int zl, zn;
        do_reset();
        acquire(rel + 10, zl);
        zn = zl + HI;
        zc_pulse(zn, 5);
        at_cyc(zn + 2);
        chk("R9 late edge inside window keeps lock", mains_lock, 1'b1);
        zc_pulse(zn + P / 2, 5);
        at_cyc(zn + P / 2 + 1);
        chk("R9 lock until early edge acts", mains_lock, 1'b1);
        at_cyc(zn + P / 2 + 2);
        chk("R9 early edge clears lock", mains_lock, 1'b0);
    endtask

    initial begin
        t_reset_state();
        t_free_run();
        t_zero_adj();
        t_offset(8'd100, "R4");
        t_offset(8'd255, "R11");
        t_level_hold();
        t_slots();
        t_adj_change();
        t_lock_timeout();
        t_lock_window();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule